// File: doc/BRIEF.md
# Four-Channel ADC Frame Sequencer

This block is an SPI host for a four-channel delta-sigma converter that talks in frames made of 24-bit words. After reset it holds the converter in reset for a set time, releases it, waits again, and then runs a fixed start-up sequence. It reads the device identity register, using a request frame followed by a null frame that carries the reply. It then writes the nine configuration registers in one burst and sends the command that starts conversions. If the identity byte is wrong, it raises a sticky error flag and stops.

Once conversions are running, every falling edge of the converter's data-ready line starts one data frame. The four 24-bit channel words in that frame are sign-extended to 32 bits and presented together with a one-cycle valid pulse. A data-ready edge that arrives during a frame is remembered and served as soon as that frame ends.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset `adc_rst_n` is low for exactly RST_LOW_CYC clock cycles, then high. `spi_cs_n` stays high while `adc_rst_n` is low and for at least RST_WAIT_CYC cycles after it rises.
- R2: SPI uses mode 1. `spi_sclk` is low whenever `spi_cs_n` is high. MOSI changes only on rising SCLK, and MISO is sampled on falling SCLK. Every byte is sent MSB first, and each frame carries a whole number of bytes.
- R3: The first frame is 15 bytes long: byte 0 is 0x20 (the read command ORed with register 0x00) and all other bytes are 0x00.
- R4: The second frame is 15 bytes of 0x00. Byte 1 of the MISO reply in this frame is the identity value, and 0x04 lets the sequence go on.
- R5: Any other identity value sets `id_err`, which stays set until reset. After that no further frame starts, and data-ready edges are ignored.
- R6: The third frame is 18 bytes: 0x6B, 0x08, 0x00, then 78 00 00, 02 20 00, 0F 00 00, 00 00 00, 00 00 00. That is register values two per word, with the low byte of each word zero.
- R7: The fourth frame is 3 bytes: 0x00, 0x33, 0x00.
- R8: After the fourth frame, each falling edge of `drdy_n` starts exactly one 15-byte frame of all-zero MOSI bytes. No frame starts without such an edge.
- R9: MISO bytes 3..5, 6..8, 9..11 and 12..14 of a data frame are channels 0..3, MSB first. Channel c appears sign-extended in `sample_o[32*c+31:32*c]`. All four channels update together, in the same cycle as a one-cycle `sample_vld` pulse that follows the end of the frame, and `sample_o` does not change at any other time.
- R10: A `drdy_n` falling edge during a data frame is held and causes exactly one more frame after the current one ends.
- R11: `drdy_n` falling edges before the fourth frame has finished cause no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |
| spi_cs_n | output | 1 | Active-low chip select, low for one frame |
| drdy_n | input | 1 | Converter data-ready, falling edge active |
| adc_rst_n | output | 1 | Active-low reset to the converter |
| sample_o | output | 128 | Four sign-extended samples, channel 0 in the low bits |
| sample_vld | output | 1 | One-cycle pulse when sample_o is refreshed |
| id_err | output | 1 | Sticky identity mismatch flag |

## Verification
A behavioural converter model in the bench captures every frame and answers from a queue. The start-up frames are compared byte for byte. Data frames are fed channel values at the sign boundaries (0x7FFFFF, 0x800000, 0xFFFFFF, 0x000001) and a mixed pattern. This shows whether byte order, word-to-channel mapping and sign extension are correct. Single edges, an edge inside a running frame, and edges sent during start-up tell apart correct edge latching from dropped, doubled or premature frames. A second run with a wrong identity shows that the sequence halts and the flag holds.

// File: rtl/adcseq_pkg.sv
// Package: shared constants, frame kinds and the configuration table.
// Assumes 24-bit words with commands in the upper 16 bits.
package adcseq_pkg;
    localparam int WORD_BYTES  = 3;
    localparam int DATA_BYTES  = 15;
    localparam int CFG_BYTES   = 18;
    localparam int WAKE_BYTES  = 3;
    localparam int LEN_W       = 5;
    localparam logic [7:0]  RD_ONE    = 8'h20;
    localparam logic [7:0]  WR_MANY   = 8'h60;
    localparam logic [7:0]  IDENT_REG = 8'h00;
    localparam logic [7:0]  IDENT_OK  = 8'h04;
    localparam logic [7:0]  CFG_BASE  = 8'h0B;
    localparam int          CFG_COUNT = 9;
    localparam logic [15:0] START_CMD = 16'h0033;

    typedef enum logic [2:0] {
        FK_RDREQ, FK_RDRPLY, FK_CFG, FK_WAKE, FK_DATA
    } frame_kind_t;

    // Value written to the n-th configured register.
    function automatic logic [7:0] cfg_value(input int n);
        case (n)
            0: return 8'h78;
            2: return 8'h02;
            3: return 8'h20;
            4: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    // Payload byte j (counted after the command word) of the burst.
    function automatic logic [7:0] cfg_byte(input int j);
        int w;
        int p;
        w = j / WORD_BYTES;
        p = j % WORD_BYTES;
        if (p == 2 || (2 * w + p) >= CFG_COUNT) return 8'h00;
        return cfg_value(2 * w + p);
    endfunction
endpackage

// File: rtl/adcseq_spi_engine.sv
// SPI mode-1 byte engine: one CS-low frame of nbytes bytes, MSB first.
// Assumes tx_byte follows byte_idx combinationally; SCLK half period is
// CLK_DIV clock cycles.
module adcseq_spi_engine #(
    parameter int CLK_DIV = 2,
    parameter int LEN_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] nbytes,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic [LEN_W-1:0] byte_idx,
    output logic [LEN_W-1:0] rx_idx,
    output logic [7:0]       rx_byte,
    output logic             rx_vld,
    output logic             done
);
    localparam int DIV_W = $clog2(CLK_DIV) + 1;

    typedef enum logic [2:0] {E_IDLE, E_LEAD, E_HIGH, E_LOW, E_TAIL, E_GAP} eng_t;
    eng_t             st;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [6:0]       shreg;
    logic [LEN_W-1:0] len;
    logic             tick;

    assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));

    // Frame sequencing, clock generation and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= E_IDLE; div_cnt <= '0; bit_idx <= 3'd7; shreg <= '0;
            len <= '0; sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1;
            byte_idx <= '0; rx_idx <= '0; rx_byte <= '0;
            rx_vld <= 1'b0; done <= 1'b0;
        end else begin
            rx_vld <= 1'b0;
            done   <= 1'b0;
            if (st != E_IDLE) div_cnt <= tick ? '0 : div_cnt + 1'b1;
            case (st)
                E_IDLE: if (start) begin
                    cs_n <= 1'b0; len <= nbytes; byte_idx <= '0;
                    bit_idx <= 3'd7; div_cnt <= '0; st <= E_LEAD;
                end
                E_LEAD, E_LOW: if (tick) begin
                    sclk <= 1'b1; mosi <= tx_byte[bit_idx]; st <= E_HIGH;
                end
                E_HIGH: if (tick) begin
                    sclk  <= 1'b0;
                    shreg <= {shreg[5:0], miso};
                    st    <= E_LOW;
                    if (bit_idx == 3'd0) begin
                        rx_byte <= {shreg, miso};
                        rx_idx  <= byte_idx;
                        rx_vld  <= 1'b1;
                        bit_idx <= 3'd7;
                        if (byte_idx == len - 1'b1) st <= E_TAIL;
                        else byte_idx <= byte_idx + 1'b1;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                E_TAIL: if (tick) begin
                    cs_n <= 1'b1; mosi <= 1'b0; st <= E_GAP;
                end
                E_GAP: if (tick) begin
                    done <= 1'b1; st <= E_IDLE;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R2
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$rose(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/adcseq_edge_det.sv
// Falling-edge detector for an asynchronous active-low strobe.
// Assumes the strobe stays low at least two clock cycles.
module adcseq_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic fall
);
    logic [SYNC:0] pipe;

    // Synchronizer chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[SYNC-1:0], din_n};
    end

    assign fall = pipe[SYNC] & ~pipe[SYNC-1];
endmodule

// File: rtl/adc_frame_seq.sv
// Start-up and conversion sequencer for a four-channel frame-based ADC.
// Assumes the converter answers a register read in the frame that follows.
module adc_frame_seq
    import adcseq_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int RST_LOW_CYC  = 1000,
    parameter int RST_WAIT_CYC = 1000,
    parameter int N_CH         = 4,
    parameter int SMP_W        = 24,
    parameter int OUT_W        = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               spi_cs_n,
    input  logic               drdy_n,
    output logic               adc_rst_n,
    output logic [N_CH*OUT_W-1:0] sample_o,
    output logic               sample_vld,
    output logic               id_err
);
    localparam int ACC_W = N_CH * SMP_W;
    localparam int CNT_MAX = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef enum logic [2:0] {S_RLOW, S_RWAIT, S_XFER, S_RUN, S_HALT} seq_t;
    seq_t             st;
    frame_kind_t      kind;
    logic [CNT_W-1:0] cnt;
    logic             go, armed, pend, fall;
    logic [7:0]       ident, tx_byte, rx_byte;
    logic [LEN_W-1:0] nbytes, tx_idx, rx_idx;
    logic             rx_vld, done;
    logic [ACC_W-1:0] acc;

    adcseq_spi_engine #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(go), .nbytes(nbytes),
        .tx_byte(tx_byte), .miso(spi_miso), .sclk(spi_sclk),
        .mosi(spi_mosi), .cs_n(spi_cs_n), .byte_idx(tx_idx),
        .rx_idx(rx_idx), .rx_byte(rx_byte), .rx_vld(rx_vld), .done(done));

    adcseq_edge_det #(.SYNC(2)) u_drdy (
        .clk(clk), .rst_n(rst_n), .din_n(drdy_n), .fall(fall));

    // Frame length by kind.
    always_comb begin
        case (kind)
            FK_CFG:  nbytes = LEN_W'(CFG_BYTES);
            FK_WAKE: nbytes = LEN_W'(WAKE_BYTES);
            default: nbytes = LEN_W'(DATA_BYTES);
        endcase
    end

    // Outgoing byte for the current frame kind and byte position.
    always_comb begin
        tx_byte = 8'h00;
        case (kind)
            FK_RDREQ: if (tx_idx == 0) tx_byte = RD_ONE | IDENT_REG;
            FK_CFG: begin
                if (tx_idx == 0)      tx_byte = WR_MANY | CFG_BASE;
                else if (tx_idx == 1) tx_byte = 8'(CFG_COUNT - 1);
                else if (int'(tx_idx) >= WORD_BYTES)
                    tx_byte = cfg_byte(int'(tx_idx) - WORD_BYTES);
            end
            FK_WAKE: begin
                if (tx_idx == 0)      tx_byte = START_CMD[15:8];
                else if (tx_idx == 1) tx_byte = START_CMD[7:0];
            end
            default: tx_byte = 8'h00;
        endcase
    end

    // Collect identity byte and channel payload from received bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident <= '0; acc <= '0;
        end else if (rx_vld) begin
            if (kind == FK_RDRPLY && rx_idx == 1) ident <= rx_byte;
            if (kind == FK_DATA && int'(rx_idx) >= WORD_BYTES)
                acc <= {acc[ACC_W-9:0], rx_byte};
        end
    end

    // Pending data-ready request: set by an armed edge, cleared when served.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend <= 1'b0;
        else if (fall && armed)  pend <= 1'b1;
        else if (st == S_RUN)    pend <= 1'b0;
    end

    // Main start-up and run sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_RLOW; kind <= FK_RDREQ; cnt <= '0; go <= 1'b0;
            armed <= 1'b0; adc_rst_n <= 1'b0; id_err <= 1'b0;
            sample_vld <= 1'b0;
        end else begin
            go <= 1'b0;
            sample_vld <= 1'b0;
            case (st)
                S_RLOW: if (cnt == CNT_W'(RST_LOW_CYC - 1)) begin
                    adc_rst_n <= 1'b1; cnt <= '0; st <= S_RWAIT;
                end else cnt <= cnt + 1'b1;
                S_RWAIT: if (cnt == CNT_W'(RST_WAIT_CYC - 1)) begin
                    kind <= FK_RDREQ; go <= 1'b1; st <= S_XFER;
                end else cnt <= cnt + 1'b1;
                S_XFER: if (done) begin
                    case (kind)
                        FK_RDREQ:  begin kind <= FK_RDRPLY; go <= 1'b1; end
                        FK_RDRPLY: if (ident == IDENT_OK) begin
                            kind <= FK_CFG; go <= 1'b1;
                        end else begin
                            id_err <= 1'b1; st <= S_HALT;
                        end
                        FK_CFG:    begin kind <= FK_WAKE; go <= 1'b1; end
                        FK_WAKE:   begin armed <= 1'b1; st <= S_RUN; end
                        default: begin
                            sample_vld <= 1'b1; st <= S_RUN;
                        end
                    endcase
                end
                S_RUN: if (pend) begin
                    kind <= FK_DATA; go <= 1'b1; st <= S_XFER;
                end
                default: st <= S_HALT;
            endcase
        end
    end

    // Channel registers, refreshed together with the valid pulse.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int HI = ACC_W - 1 - c * SMP_W;
        always_ff @(posedge clk) begin
            if (!rst_n) sample_o[c*OUT_W +: OUT_W] <= '0;
            else if (st == S_XFER && done && kind == FK_DATA)
                sample_o[c*OUT_W +: OUT_W] <=
                    {{(OUT_W-SMP_W){acc[HI]}}, acc[HI -: SMP_W]};
        end
    end

    // R1
    cs_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rst_n |-> spi_cs_n);
    // R5
    id_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |=> (id_err && spi_cs_n));
    // R9
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);
    // R9
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> sample_vld);
endmodule

// File: tb/tb_adc_frame_seq.sv
// Bench: behavioural converter model, frame log and per-clock monitors.
module tb_adc_frame_seq;
    localparam int RLOW = 20;
    localparam int RWAIT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk, spi_mosi, spi_cs_n, adc_rst_n, sample_vld, id_err;
    logic spi_miso = 1'b0;
    logic drdy_n = 1'b1;
    logic [127:0] sample_o;

    int n_run = 0, n_fail = 0;
    int fcnt = 0, vcnt = 0, mon_bad = 0;
    logic [7:0] ident_val = 8'h04;
    logic [7:0] fb [0:15][0:19];
    int flen [0:15];
    logic [7:0] rep [0:19];
    logic [95:0]  rq[$];
    logic [127:0] eq[$];
    int bitc = 0;
    logic [7:0] cur = 0;
    bit in_frame = 0;

    always #5 clk = ~clk;

    adc_frame_seq #(.CLK_DIV(2), .RST_LOW_CYC(RLOW), .RST_WAIT_CYC(RWAIT)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .drdy_n(drdy_n),
        .adc_rst_n(adc_rst_n), .sample_o(sample_o), .sample_vld(sample_vld),
        .id_err(id_err));

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: frame start loads the reply bytes.
    always @(negedge spi_cs_n) begin
        logic [95:0] r;
        in_frame = 1; bitc = 0; cur = 0;
        for (int i = 0; i < 20; i++) rep[i] = 8'h00;
        if (fcnt == 1) begin rep[0] = 8'h00; rep[1] = ident_val; end
        if (fcnt >= 4 && rq.size() > 0) begin
            r = rq.pop_front();
            for (int k = 0; k < 12; k++) rep[3+k] = r[95-8*k -: 8];
        end
    end
    // Converter drives MISO on rising SCLK.
    always @(posedge spi_sclk) if (in_frame && bitc < 160)
        spi_miso <= rep[bitc/8][7 - bitc%8];
    // Converter samples MOSI on falling SCLK.
    always @(negedge spi_sclk) if (in_frame) begin
        cur = {cur[6:0], spi_mosi};
        bitc++;
        if (bitc % 8 == 0 && bitc/8 <= 20 && fcnt < 16) fb[fcnt][bitc/8-1] = cur;
    end
    // Frame end: record length.
    always @(posedge spi_cs_n) if (in_frame) begin
        in_frame = 0;
        if (fcnt < 16) flen[fcnt] = bitc;
        fcnt++;
    end

    // Per-clock monitor: compares outputs with the bench model state.
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n && spi_sclk) mon_bad++;         // R2
        if (!adc_rst_n && !spi_cs_n) mon_bad++;      // R1
        if (sample_vld) begin                        // R9
            vcnt++;
            if (eq.size() == 0) chk(0, "R9 unexpected valid", sample_o, 0);
            else begin
                logic [127:0] e;
                e = eq.pop_front();
                chk(sample_o == e, "R9 samples", sample_o, e);
            end
        end
    end

    task automatic push_data(input logic [23:0] a, b, c, d);
        logic [127:0] e;
        rq.push_back({a, b, c, d});
        e = {{{8{d[23]}}, d}, {{8{c[23]}}, c}, {{8{b[23]}}, b}, {{8{a[23]}}, a}};
        eq.push_back(e);
    endtask

    task automatic pulse_drdy();
        @(negedge clk) drdy_n = 1'b0;
        repeat (4) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic wait_frames(input int n);
        int t = 0;
        while (fcnt < n && t < 20000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic check_frame(input int f, input int nb, input string req,
                               input logic [7:0] e0, e1, input int cfg);
        logic [7:0] e;
        chk(flen[f] == nb*8, {req, " length bits"}, flen[f], nb*8);
        for (int i = 0; i < nb; i++) begin
            e = 8'h00;
            if (i == 0) e = e0;
            if (i == 1) e = e1;
            if (cfg != 0) begin
                case (i)
                    3: e = 8'h78; 6: e = 8'h02; 7: e = 8'h20; 9: e = 8'h0F;
                    default: ;
                endcase
            end
            chk(fb[f][i] == e, req, fb[f][i], e);
        end
    endtask

    task automatic do_reset();
        int n;
        rst_n = 1'b0; fcnt = 0; vcnt = 0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1 && spi_sclk == 0 && adc_rst_n == 0 && id_err == 0
            && sample_vld == 0 && sample_o == 0, "R1 reset state",
            {spi_cs_n, spi_sclk, adc_rst_n, id_err, sample_vld}, 5'b10000);
        rst_n = 1'b1;
        n = 0;
        while (adc_rst_n == 0 && n < 1000) begin n++; @(negedge clk); end
        chk(n == RLOW, "R1 reset low cycles", n, RLOW);
        n = 0;
        while (spi_cs_n == 1 && n < 1000) begin n++; @(negedge clk); end
        chk(n >= RWAIT, "R1 wait before first access", n, RWAIT);
    endtask

    initial begin
        int t;
        // Watchdog.
        fork
            begin
                #1500000;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none

        do_reset();
        wait_frames(3);
        pulse_drdy();                                // R11 edge during start-up
        wait_frames(4);
        check_frame(0, 15, "R3 read request", 8'h20, 8'h00, 0);
        check_frame(1, 15, "R4 null reply frame", 8'h00, 8'h00, 0);
        check_frame(2, 18, "R6 config burst", 8'h6B, 8'h08, 1);
        check_frame(3, 3,  "R7 wakeup", 8'h00, 8'h33, 0);
        repeat (300) @(negedge clk);
        chk(fcnt == 4, "R11/R8 no frame without edge", fcnt, 4);

        push_data(24'h7FFFFF, 24'h800000, 24'h000001, 24'hFFFFFF);
        pulse_drdy();
        wait_frames(5);
        check_frame(4, 15, "R8 data frame", 8'h00, 8'h00, 0);
        chk(vcnt == 1, "R9 one valid per frame", vcnt, 1);

        push_data(24'h123456, 24'hABCDEF, 24'h000000, 24'h400000);
        pulse_drdy();
        wait_frames(6);
        chk(vcnt == 2, "R9 second sample set", vcnt, 2);

        // R10: second edge arrives mid-frame.
        push_data(24'h000010, 24'hFFFFF0, 24'h7F0000, 24'h8000FF);
        push_data(24'h111111, 24'h222222, 24'hEEEEEE, 24'h333333);
        pulse_drdy();
        t = 0;
        while (spi_cs_n && t < 1000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        pulse_drdy();
        wait_frames(8);
        repeat (300) @(negedge clk);
        chk(fcnt == 8, "R10 latched edge gives one extra frame", fcnt, 8);
        chk(vcnt == 4, "R10 valid pulses", vcnt, 4);
        check_frame(7, 15, "R8 latched data frame", 8'h00, 8'h00, 0);
        chk(mon_bad == 0, "R2 SCLK idle / R1 CS in reset monitor", mon_bad, 0);

        // R5: wrong identity halts.
        ident_val = 8'h05;
        do_reset();
        wait_frames(2);
        repeat (100) @(negedge clk);
        chk(id_err == 1, "R5 id_err set", id_err, 1);
        pulse_drdy();
        repeat (400) @(negedge clk);
        chk(fcnt == 2, "R5 no frame after mismatch", fcnt, 2);
        chk(id_err == 1 && vcnt == 0, "R5 flag sticky, no samples",
            {id_err, 8'(vcnt)}, 9'h100);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule